// File: doc/BRIEF.md
# Synchronous Serial Port with Selectable Clock Source

This block moves one byte at a time over a clocked serial link. A single 8-bit shift register does double duty: while it pushes a previously loaded byte out on `sdo`, it pulls the incoming bits from `sdi` into the positions that the outgoing bits have left. At the end of a transfer the register holds the received byte, which the host reads in parallel from `rx_data`.

The serial clock has four possible sources, chosen by `clk_sel`. Three values make the port the master: it then divides the system clock by 2, 4 or 8 and drives the clock pin. The fourth value makes it a slave: it resynchronises an external clock and follows that clock's edges. A pulse on `trigger` arms a transfer. The port then counts eight clock pulses, sets an interrupt flag and, as a slave, tells the remote master through `ready` when it may start clocking. Bit order and the edge used to launch data are both selectable.

Top module: `sync_serial_port`

## Requirements
- R1: While no transfer is in progress, a `load_valid` pulse writes `load_data` into the shift register, and `rx_data` shows that value from the next clock edge.
- R2: In master mode, `clk_sel` values 00, 01 and 10 give a serial clock of the system clock divided by 2, 4 and 8. `busy` then stays high for exactly 16, 32 and 64 system clocks after the edge that accepts the trigger.
- R3: The serial clock idles high. `sclk_oe` is 1 for the three master values of `clk_sel` and 0 for the slave value 11.
- R4: With `lsb_first`=1, bit 0 is sent first and the first bit received ends up in bit 0. With `lsb_first`=0, bit 7 is sent first and the first bit received ends up in bit 7.
- R5: With `edge_sel`=0, data changes on the falling serial-clock edge and is sampled on the rising edge. With `edge_sel`=1 this is reversed. The first outgoing bit is already on `sdo` from the cycle after the trigger.
- R6: After eight clock pulses, the remote side has received exactly the byte that was loaded, and `rx_data` holds the byte that was presented on `sdi`.
- R7: In slave mode (`clk_sel`=11), the port takes its clock from `sclk_in` through a two-stage synchroniser. The transfer ends on the eighth rising edge of that clock.
- R8: In slave mode, `ready` goes high on the cycle after the trigger and goes low once the first external falling edge has been detected. In master mode `ready` stays low.
- R9: `irq_flag` is set when a transfer completes and is cleared by an `irq_clr` pulse. `irq` equals `irq_flag` gated by `irq_en`.
- R10: A `trigger` or `load_valid` that arrives while `busy` is high has no effect on the running transfer, its length or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_sel | input | 2 | 00/01/10 master divide by 2/4/8, 11 slave |
| lsb_first | input | 1 | 1 = least significant bit first |
| edge_sel | input | 1 | 0 = launch on fall, sample on rise; 1 = reverse |
| load_valid | input | 1 | Parallel load strobe |
| load_data | input | 8 | Byte to transmit |
| trigger | input | 1 | Starts a transfer |
| sdi | input | 1 | Serial data in |
| sclk_in | input | 1 | External serial clock (slave mode) |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the interrupt flag |
| sdo | output | 1 | Serial data out |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Output enable for the clock pad |
| rx_data | output | 8 | Shift register contents |
| busy | output | 1 | Transfer in progress |
| ready | output | 1 | Slave ready indication |
| irq_flag | output | 1 | Transfer-complete flag |
| irq | output | 1 | Masked interrupt |

## Verification
In master mode, toggle k of the serial clock falls on the k-th multiple of the half period after the trigger edge, so `busy` drops exactly 16, 32 or 64 edges later. The bench counts the falling-clock samples until it sees `busy` low and compares that count with the number required for the rate. In slave mode, each external edge takes two to three system clocks to pass the synchroniser, so the bench holds every external level for four clocks and reads `sdo` and `ready` only after that margin. Flags, loads and `rx_data` are read on the falling clock that follows the edge they are due on, never at the same edge.

// File: rtl/ssp_pkg.sv
// Shared types and helpers for the synchronous serial port.
// Assumes the clock select is a 2-bit code with value 3 meaning slave mode.
package ssp_pkg;

    typedef enum logic [1:0] {
        SEL_DIV2  = 2'b00,
        SEL_DIV4  = 2'b01,
        SEL_DIV8  = 2'b10,
        SEL_SLAVE = 2'b11
    } clk_src_e;

    // Number of system clocks per half period of the master serial clock.
    function automatic int unsigned half_cycles(input logic [1:0] sel);
        return 32'd1 << sel;
    endfunction

endpackage

// File: rtl/ssp_clk_gen.sv
// Master-mode serial clock generator.
// Divides the system clock and toggles a serial clock that idles high.
// Emits one-cycle pulses in the same cycle as each toggle so that the
// data path acts on the edge the toggle is registered on.
// Assumes rate_sel is held stable while run is high.
module ssp_clk_gen #(
    parameter int MAX_HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate_sel,
    output logic       sclk,
    output logic       fall_ev,
    output logic       rise_ev
);
    localparam int CW = $clog2(MAX_HALF + 1);

    logic [CW-1:0] div_q;
    logic [CW-1:0] last_cnt;
    logic          sclk_q;
    logic          tick;

    // Terminal count of the divider for the selected rate.
    always_comb begin
        last_cnt = CW'(ssp_pkg::half_cycles(rate_sel) - 1);
        tick     = run && (div_q == last_cnt);
        fall_ev  = tick && sclk_q;
        rise_ev  = tick && !sclk_q;
    end

    // Divider counter and clock toggle; clock returns high when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            sclk_q <= 1'b1;
        end else if (!run) begin
            div_q  <= '0;
            sclk_q <= 1'b1;
        end else if (tick) begin
            div_q  <= '0;
            sclk_q <= !sclk_q;
        end else begin
            div_q  <= div_q + 1'b1;
        end
    end

    assign sclk = sclk_q;

endmodule

// File: rtl/ssp_edge_sync.sv
// Slave-mode clock receiver.
// Resynchronises an asynchronous external clock through STAGES flops and
// flags its rising and falling edges one cycle wide.
// Assumes the external clock stays at each level for at least
// STAGES+1 system clocks.
module ssp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    output logic fall_ev,
    output logic rise_ev
);
    logic [STAGES:0] pipe_q;

    // Synchroniser chain plus one history flop; resets to the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], ext_clk};
        end
    end

    // Edge detection on the synchronised level against its previous value.
    always_comb begin
        fall_ev = pipe_q[STAGES] && !pipe_q[STAGES-1];
        rise_ev = !pipe_q[STAGES] && pipe_q[STAGES-1];
    end

endmodule

// File: rtl/ssp_shifter.sv
// Shared transmit/receive shift register with an output latch.
// The latch takes the outgoing bit on start and on every launch event;
// the register shifts sdi in on every capture event, in the direction
// set by lsb_first. A parallel load is honoured only when load_en is high.
module ssp_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    input  logic              start,
    input  logic              launch,
    input  logic              capture,
    input  logic              lsb_first,
    input  logic              sdi,
    output logic [DATA_W-1:0] sreg,
    output logic              sdo
);
    logic [DATA_W-1:0] sreg_q;
    logic              sdo_q;
    logic              out_bit;

    // Bit waiting at the outgoing end of the register.
    assign out_bit = lsb_first ? sreg_q[0] : sreg_q[DATA_W-1];

    // Parallel load, serial shift and output latch update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            sdo_q  <= 1'b1;
        end else begin
            if (load_en) begin
                sreg_q <= load_data;
            end else if (capture) begin
                if (lsb_first) sreg_q <= {sdi, sreg_q[DATA_W-1:1]};
                else           sreg_q <= {sreg_q[DATA_W-2:0], sdi};
            end
            if (start || launch) begin
                sdo_q <= out_bit;
            end
        end
    end

    assign sreg = sreg_q;
    assign sdo  = sdo_q;

endmodule

// File: rtl/sync_serial_port.sv
// Synchronous serial port top level.
// Selects the master clock generator or the slave edge receiver, counts
// DATA_W serial clock pulses per transfer, sequences busy, ready and the
// interrupt flag. Assumes clk_sel, lsb_first and edge_sel are static for
// the duration of a transfer.
module sync_serial_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_HALF    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        clk_sel,
    input  logic              lsb_first,
    input  logic              edge_sel,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_data,
    input  logic              trigger,
    input  logic              sdi,
    input  logic              sclk_in,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              sdo,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              ready,
    output logic              irq_flag,
    output logic              irq
);
    import ssp_pkg::*;

    localparam int CNT_W = $clog2(DATA_W);

    logic             is_slave;
    logic             busy_q;
    logic             ready_q;
    logic             flag_q;
    logic [CNT_W-1:0] pulse_q;
    logic             start;
    logic             done;
    logic             m_fall, m_rise;
    logic             s_fall, s_rise;
    logic             ev_fall, ev_rise;
    logic             launch, capture;

    assign is_slave = (clk_src_e'(clk_sel) == SEL_SLAVE);
    assign start    = trigger && !busy_q;

    ssp_clk_gen #(
        .MAX_HALF (MAX_HALF)
    ) u_clk_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy_q && !is_slave),
        .rate_sel (clk_sel),
        .sclk     (sclk_out),
        .fall_ev  (m_fall),
        .rise_ev  (m_rise)
    );

    ssp_edge_sync #(
        .STAGES  (SYNC_STAGES)
    ) u_edge_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_clk (sclk_in),
        .fall_ev (s_fall),
        .rise_ev (s_rise)
    );

    // Merge the clock source events, gated to an active transfer.
    always_comb begin
        if (is_slave) begin
            ev_fall = busy_q && s_fall;
            ev_rise = busy_q && s_rise;
        end else begin
            ev_fall = m_fall;
            ev_rise = m_rise;
        end
        launch  = edge_sel ? ev_rise : ev_fall;
        capture = edge_sel ? ev_fall : ev_rise;
        done    = ev_rise && (pulse_q == CNT_W'(DATA_W - 1));
    end

    ssp_shifter #(
        .DATA_W    (DATA_W)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_valid && !busy_q),
        .load_data (load_data),
        .start     (start),
        .launch    (launch),
        .capture   (capture),
        .lsb_first (lsb_first),
        .sdi       (sdi),
        .sreg      (rx_data),
        .sdo       (sdo)
    );

    // Transfer sequencing: busy window and serial pulse counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            pulse_q <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            pulse_q <= '0;
        end else if (done) begin
            busy_q  <= 1'b0;
            pulse_q <= '0;
        end else if (ev_rise) begin
            pulse_q <= pulse_q + 1'b1;
        end
    end

    // Slave ready indication: armed by the trigger, dropped at first clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else if (start && is_slave) begin
            ready_q <= 1'b1;
        end else if (ev_fall || done) begin
            ready_q <= 1'b0;
        end
    end

    // Completion flag: set at end of transfer, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (done) begin
            flag_q <= 1'b1;
        end else if (irq_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign sclk_oe  = !is_slave;
    assign busy     = busy_q;
    assign ready    = ready_q;
    assign irq_flag = flag_q;
    assign irq      = flag_q && irq_en;

endmodule

// File: rtl/sync_serial_port_chk.sv
// Property checker for the synchronous serial port, bound to every
// instance of the top module. Observes ports only.
module sync_serial_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        clk_sel,
    input logic              trigger,
    input logic              load_valid,
    input logic [DATA_W-1:0] load_data,
    input logic              sclk_out,
    input logic [DATA_W-1:0] rx_data,
    input logic              busy,
    input logic              ready,
    input logic              irq_flag,
    input logic              irq
);
    logic [15:0] busy_len;

    // Length of the current busy window in system clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    // R2: a master transfer lasts 16 half-period units of its rate
    p_master_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(clk_sel) != 2'b11) |-> busy_len == (16'd16 << $past(clk_sel)));

    // R1: an idle load appears on rx_data one edge later
    p_idle_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load_valid) |=> rx_data == $past(load_data));

    // R3: serial clock is high whenever no transfer is running
    p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_out);

    // R8: ready only during a slave transfer
    p_ready_slave_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (busy && clk_sel == 2'b11));

    // R9: the flag rises only as a transfer ends
    p_flag_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $fell(busy));

    // R9: the interrupt never fires without the flag
    p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_flag);

    // R10: a transfer only begins on a trigger
    p_start_trig_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(trigger));

endmodule

bind sync_serial_port sync_serial_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_sel    (clk_sel),
    .trigger    (trigger),
    .load_valid (load_valid),
    .load_data  (load_data),
    .sclk_out   (sclk_out),
    .rx_data    (rx_data),
    .busy       (busy),
    .ready      (ready),
    .irq_flag   (irq_flag),
    .irq        (irq)
);

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_sel = 2'b00;
    logic       lsb_first = 1'b1;
    logic       edge_sel = 1'b0;
    logic       load_valid = 1'b0;
    logic [7:0] load_data = 8'h00;
    logic       trigger = 1'b0;
    logic       sdi = 1'b0;
    logic       sclk_in = 1'b1;
    logic       irq_en = 1'b0;
    logic       irq_clr = 1'b0;
    logic       sdo, sclk_out, sclk_oe, busy, ready, irq_flag, irq;
    logic [7:0] rx_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // Vector layout: [19:18] clk_sel, [17] lsb_first, [16] edge_sel,
    // [15:8] byte loaded for sending, [7:0] byte the remote side sends.
    localparam logic [19:0] VEC [0:7] = '{
        {2'b00, 1'b1, 1'b0, 8'hA5, 8'h3C},
        {2'b01, 1'b0, 1'b0, 8'h96, 8'hC3},
        {2'b10, 1'b1, 1'b1, 8'h81, 8'h7E},
        {2'b00, 1'b0, 1'b1, 8'h5A, 8'hF0},
        {2'b01, 1'b1, 1'b1, 8'h01, 8'h80},
        {2'b11, 1'b1, 1'b0, 8'hC8, 8'h13},
        {2'b11, 1'b0, 1'b0, 8'h37, 8'hE4},
        {2'b10, 1'b0, 1'b0, 8'hFF, 8'h00}
    };

    sync_serial_port u_sync_serial_port (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .lsb_first(lsb_first),
        .edge_sel(edge_sel), .load_valid(load_valid), .load_data(load_data),
        .trigger(trigger), .sdi(sdi), .sclk_in(sclk_in), .irq_en(irq_en),
        .irq_clr(irq_clr), .sdo(sdo), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .rx_data(rx_data), .busy(busy), .ready(ready), .irq_flag(irq_flag),
        .irq(irq)
    );

    always #2 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Remote partner for master transfers.
    logic [7:0] p_byte = 8'h00;
    logic [7:0] cap_byte = 8'h00;
    int  cidx = 0;
    bit  m_active = 1'b0;

    function automatic int pos(input int i);
        return lsb_first ? i : 7 - i;
    endfunction

    // Sample sdo and present the next bit on each capture edge.
    always @(sclk_out) begin
        if (m_active && sclk_out == !edge_sel && cidx < 8) begin
            cap_byte[pos(cidx)] = sdo;
            cidx = cidx + 1;
            if (cidx < 8) sdi = p_byte[pos(cidx)];
        end
    end

    task automatic load_byte(input logic [7:0] b);
        @(negedge clk); load_valid = 1'b1; load_data = b;
        @(negedge clk); load_valid = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic run_master(input logic [7:0] tx, input logic [7:0] rx, input bit inj);
        int n;
        load_byte(tx);
        p_byte = rx; cap_byte = 8'h00; cidx = 0;
        sdi = rx[pos(0)];
        m_active = 1'b1;
        chk("R3 oe master", sclk_oe, 1'b1);
        trigger = 1'b1;
        @(negedge clk); trigger = 1'b0;
        n = 0;
        while (busy && n < 200) begin
            @(negedge clk); n++;
            if (n == 5) chk("R8 ready low in master", ready, 1'b0);
            if (inj && n == 10) begin
                trigger = 1'b1; load_valid = 1'b1; load_data = 8'hFF;
            end else if (n == 11) begin
                trigger = 1'b0; load_valid = 1'b0;
            end
        end
        m_active = 1'b0;
        chk(inj ? "R10 length" : "R2 length", n, 32'd16 << clk_sel);
        chk("R6 rx_data", rx_data, rx);
        chk("R4 R5 sent byte", cap_byte, tx);
        chk("R9 flag set", irq_flag, 1'b1);
        chk("R3 idle high", sclk_out, 1'b1);
    endtask

    // Slave transfer, edge_sel=0: remote changes sdi after rising edges.
    task automatic run_slave(input logic [7:0] tx, input logic [7:0] rx);
        load_byte(tx);
        cap_byte = 8'h00;
        sdi = rx[pos(0)];
        chk("R3 oe slave", sclk_oe, 1'b0);
        trigger = 1'b1;
        @(negedge clk); trigger = 1'b0;
        chk("R8 ready armed", ready, 1'b1);
        for (int i = 0; i < 8; i++) begin
            sclk_in = 1'b0;
            repeat (4) @(negedge clk);
            cap_byte[pos(i)] = sdo;
            if (i == 0) chk("R8 ready dropped", ready, 1'b0);
            sclk_in = 1'b1;
            repeat (4) @(negedge clk);
            if (i < 7) sdi = rx[pos(i + 1)];
        end
        chk("R7 busy done", busy, 1'b0);
        chk("R7 rx_data", rx_data, rx);
        chk("R6 sent byte", cap_byte, tx);
        chk("R9 flag set", irq_flag, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset busy", busy, 1'b0);
        chk("reset sclk R3", sclk_out, 1'b1);
        chk("reset flag R9", irq_flag, 1'b0);
        chk("reset ready R8", ready, 1'b0);
        chk("reset rx", rx_data, 8'h00);
        chk("reset sdo", sdo, 1'b1);

        for (int v = 0; v < 8; v++) begin
            clk_sel   = VEC[v][19:18];
            lsb_first = VEC[v][17];
            edge_sel  = VEC[v][16];
            @(negedge clk);
            if (VEC[v][19:18] == 2'b11) run_slave(VEC[v][15:8], VEC[v][7:0]);
            else run_master(VEC[v][15:8], VEC[v][7:0], 1'b0);
            pulse_clr();
            chk("R9 flag cleared", irq_flag, 1'b0);
        end

        // R1: idle parallel load is readable
        load_byte(8'h6B);
        chk("R1 idle load", rx_data, 8'h6B);

        // R10: trigger and load while busy are ignored
        clk_sel = 2'b01; lsb_first = 1'b1; edge_sel = 1'b0;
        run_master(8'h3A, 8'hC5, 1'b1);

        // R9: masking of the interrupt
        irq_en = 1'b0;
        @(negedge clk);
        chk("R9 masked", irq, 1'b0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R9 unmasked", irq, 1'b1);
        pulse_clr();
        chk("R9 clear irq", irq, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule